// File: doc/BRIEF.md
# Bunch-by-bunch threshold longitudinal damper

This block makes a kick decision for every bunch of a circular machine on every revolution. It gets one signed phase sample per bucket per turn, together with the bucket number and a flag that marks the first sample of each turn. Each bucket has its own row in a history store, which holds that bucket's phase over the last seven turns. The current sample and those seven form an eight-turn window. A fixed derivative filter sums the four newest turns and subtracts the four oldest.

The filter result is compared against a programmable symmetric threshold. A bunch drifting one way in phase gets a fixed positive kick of programmable size. A bunch drifting the other way gets the same size with a negative sign. A bunch inside the dead band gets no kick. The output is therefore three-level rather than proportional.

A global enable silences all kicks while the history keeps updating. After reset, and again after the enable rises, kicks stay at zero until the window holds eight real turns.

Top module: `ldamp_top`

## Requirements
- R1: For every cycle with `valid_i` high, the next cycle has `kick_valid_o` high and `bucket_o` equal to that `bucket_i`. A cycle with `valid_i` low gives `kick_valid_o` low and `kick_o` zero on the next cycle.
- R2: The filter value for a sample is `x0+x1+x2+x3-x4-x5-x6-x7`. Here `x0` is the current phase (signed two's complement) and `xk` is the phase that the same bucket received k turns earlier. Every bucket keeps its own history, independent of the others.
- R3: When armed, a filter value strictly greater than `thresh_i` gives `kick_o = +kick_mag_i`. A value strictly less than `-thresh_i` gives `kick_o = -kick_mag_i`. A value equal to `+thresh_i` or `-thresh_i`, or anywhere in between, gives zero.
- R4: A phase that stays constant for eight turns gives a filter value of zero, so even with `thresh_i = 0` that bucket gets no kick.
- R5: A turn is counted when `valid_i` and `turn_start_i` are high together. Samples before the eighth counted turn give `kick_o = 0`; the sample that carries the eighth marker is the first that can kick. Both reset and `enable_i` low clear the count.
- R6: While `enable_i` is low, `kick_o` stays zero, but `kick_valid_o` and `bucket_o` still follow the input. Each sample is still written into its bucket's history.
- R7: `thresh_i` and `kick_mag_i` are taken in the same cycle as each sample, so a change applies from the next sample on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Global kick enable |
| thresh_i | input | PHASE_W+2 | Dead-band threshold, unsigned |
| kick_mag_i | input | KICK_W-1 | Kick magnitude, unsigned |
| valid_i | input | 1 | Phase sample strobe |
| turn_start_i | input | 1 | First sample of a turn |
| bucket_i | input | $clog2(NUM_BUCKETS) | Bucket index of the sample |
| phase_i | input | PHASE_W | Signed phase sample |
| kick_valid_o | output | 1 | Kick decision strobe |
| bucket_o | output | $clog2(NUM_BUCKETS) | Bucket index of the decision |
| kick_o | output | KICK_W | Signed kick: +mag, 0 or -mag |

## Verification
The hardest condition to reach from the ports is a filter value that sits exactly on the threshold. The value depends on eight turns of one bucket's history, so no single input sets it. The bench keeps its own per-bucket history. Just before a chosen sample it computes the filter value that sample will produce, then sets `thresh_i` to that magnitude and to one below it, which tests both sides of the dead-band edge. Another sequence turns the enable off across whole turns and back on. It then checks that the warm-up restarts and that decisions after it still match a history that kept updating while kicks were off.

// File: rtl/ldamp_pkg.sv
package ldamp_pkg;
  typedef enum logic [1:0] {
    KICK_NONE = 2'd0,
    KICK_POS  = 2'd1,
    KICK_NEG  = 2'd2
  } kick_dir_e;
endpackage

// File: rtl/ldamp_hist_store.sv
module ldamp_hist_store #(
  parameter int NUM_BUCKETS = 588,
  parameter int PHASE_W     = 14,
  parameter int DEPTH       = 7,
  localparam int IDX_W      = $clog2(NUM_BUCKETS)
) (
  input  logic                          clk_i,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [PHASE_W-1:0]            sample_i,
  output logic [DEPTH-1:0][PHASE_W-1:0] hist_o
);
  // one packed row per bucket; entry 0 is the previous turn
  logic [DEPTH-1:0][PHASE_W-1:0] mem_q [NUM_BUCKETS];

  assign hist_o = mem_q[idx_i];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[idx_i] <= {hist_o[DEPTH-2:0], sample_i};
  end
endmodule

// File: rtl/ldamp_fir_deriv.sv
module ldamp_fir_deriv #(
  parameter int PHASE_W = 14,
  parameter int TAPS    = 8,
  localparam int HALF   = TAPS / 2,
  localparam int FILT_W = PHASE_W + $clog2(TAPS)
) (
  input  logic signed [PHASE_W-1:0]      cur_i,
  input  logic [TAPS-2:0][PHASE_W-1:0]   hist_i,
  output logic signed [FILT_W-1:0]       filt_o
);
  logic signed [FILT_W-1:0] term [TAPS];

  assign term[0] = FILT_W'(cur_i);

  // newer half adds, older half subtracts
  for (genvar g = 1; g < TAPS; g++) begin : g_tap
    if (g < HALF) begin : g_new
      assign term[g] = FILT_W'($signed(hist_i[g-1]));
    end else begin : g_old
      assign term[g] = -FILT_W'($signed(hist_i[g-1]));
    end
  end

  always_comb begin
    filt_o = '0;
    for (int i = 0; i < TAPS; i++) filt_o = filt_o + term[i];
  end
endmodule

// File: rtl/ldamp_kick_decide.sv
module ldamp_kick_decide
  import ldamp_pkg::*;
#(
  parameter int FILT_W = 17,
  parameter int KICK_W = 12,
  parameter int IDX_W  = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     armed_i,
  input  logic [IDX_W-1:0]         bucket_i,
  input  logic signed [FILT_W-1:0] filt_i,
  input  logic [FILT_W-2:0]        thresh_i,
  input  logic [KICK_W-2:0]        mag_i,
  output logic                     kick_valid_o,
  output logic [IDX_W-1:0]         bucket_o,
  output logic signed [KICK_W-1:0] kick_o
);
  logic signed [FILT_W-1:0] thr_s;
  logic signed [KICK_W-1:0] mag_s;
  kick_dir_e                dir;

  assign thr_s = $signed({1'b0, thresh_i});
  assign mag_s = $signed({1'b0, mag_i});

  always_comb begin
    dir = KICK_NONE;
    if (armed_i) begin
      if (filt_i > thr_s)       dir = KICK_POS;
      else if (filt_i < -thr_s) dir = KICK_NEG;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kick_valid_o <= 1'b0;
      bucket_o     <= '0;
      kick_o       <= '0;
    end else begin
      kick_valid_o <= valid_i;
      if (valid_i) bucket_o <= bucket_i;
      unique case (dir)
        KICK_POS: kick_o <= valid_i ? mag_s : '0;
        KICK_NEG: kick_o <= valid_i ? -mag_s : '0;
        default:  kick_o <= '0;
      endcase
    end
  end

  assert_three_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (kick_o == '0 || kick_o == $past(mag_s) || kick_o == -$past(mag_s)));
  assert_idle_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !kick_valid_o |-> kick_o == '0);
endmodule

// File: rtl/ldamp_top.sv
module ldamp_top #(
  parameter int NUM_BUCKETS = 588,
  parameter int PHASE_W     = 14,
  parameter int TAPS        = 8,
  parameter int KICK_W      = 12,
  localparam int IDX_W      = $clog2(NUM_BUCKETS),
  localparam int FILT_W     = PHASE_W + $clog2(TAPS),
  localparam int CNT_W      = $clog2(TAPS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      enable_i,
  input  logic [FILT_W-2:0]         thresh_i,
  input  logic [KICK_W-2:0]         kick_mag_i,
  input  logic                      valid_i,
  input  logic                      turn_start_i,
  input  logic [IDX_W-1:0]          bucket_i,
  input  logic signed [PHASE_W-1:0] phase_i,
  output logic                      kick_valid_o,
  output logic [IDX_W-1:0]          bucket_o,
  output logic signed [KICK_W-1:0]  kick_o
);
  logic [TAPS-2:0][PHASE_W-1:0] hist;
  logic signed [FILT_W-1:0]     filt;
  logic [CNT_W-1:0]             turn_cnt_q, turn_cnt_d;
  logic                         armed;

  // warm-up: counted turns since reset or enable, saturating at TAPS
  always_comb begin
    turn_cnt_d = turn_cnt_q;
    if (!enable_i) turn_cnt_d = '0;
    else if (valid_i && turn_start_i && turn_cnt_q != CNT_W'(TAPS))
      turn_cnt_d = turn_cnt_q + 1'b1;
  end
  assign armed = enable_i && (turn_cnt_d == CNT_W'(TAPS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) turn_cnt_q <= '0;
    else         turn_cnt_q <= turn_cnt_d;
  end

  ldamp_hist_store #(
    .NUM_BUCKETS(NUM_BUCKETS), .PHASE_W(PHASE_W), .DEPTH(TAPS-1)
  ) hist_i (
    .clk_i   (clk_i),
    .wr_en_i (valid_i),
    .idx_i   (bucket_i),
    .sample_i(phase_i),
    .hist_o  (hist)
  );

  ldamp_fir_deriv #(.PHASE_W(PHASE_W), .TAPS(TAPS)) fir_i (
    .cur_i (phase_i),
    .hist_i(hist),
    .filt_o(filt)
  );

  ldamp_kick_decide #(.FILT_W(FILT_W), .KICK_W(KICK_W), .IDX_W(IDX_W)) dec_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .armed_i     (armed),
    .bucket_i    (bucket_i),
    .filt_i      (filt),
    .thresh_i    (thresh_i),
    .mag_i       (kick_mag_i),
    .kick_valid_o(kick_valid_o),
    .bucket_o    (bucket_o),
    .kick_o      (kick_o)
  );

  assert_valid_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> kick_valid_o && bucket_o == $past(bucket_i));
  assert_no_spurious_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !kick_valid_o);
  assert_warmup_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && turn_cnt_q < CNT_W'(TAPS-1) |=> kick_o == '0);
  assert_disable_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !enable_i |=> kick_o == '0);
endmodule

// File: tb/ldamp_top_tb.sv
module ldamp_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 24;
  localparam int PW   = 14;
  localparam int KW   = 12;
  localparam int FW   = PW + 3;
  localparam int IW   = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [FW-2:0] thresh = '0;
  logic [KW-2:0] mag = '0;
  logic vld = 1'b0;
  logic ts = 1'b0;
  logic [IW-1:0] bkt = '0;
  logic signed [PW-1:0] ph = '0;
  logic kv;
  logic [IW-1:0] bo;
  logic signed [KW-1:0] ko;

  int total = 0;
  int bad = 0;
  int hm [NB][7];
  int cnt = 0;
  int base [NB];
  int slope [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  ldamp_top #(.NUM_BUCKETS(NB), .PHASE_W(PW), .TAPS(8), .KICK_W(KW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .thresh_i(thresh),
    .kick_mag_i(mag), .valid_i(vld), .turn_start_i(ts), .bucket_i(bkt),
    .phase_i(ph), .kick_valid_o(kv), .bucket_o(bo), .kick_o(ko));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_filt(int b, int p);
    return p + hm[b][0] + hm[b][1] + hm[b][2] - hm[b][3] - hm[b][4] - hm[b][5] - hm[b][6];
  endfunction

  function automatic int iabs(int v);
    return v < 0 ? -v : v;
  endfunction

  // drive one sample at a falling edge, check at the next falling edge
  task automatic step(int b, int p, bit first, string tag);
    int cn, f, k;
    bit armed;
    vld = 1'b1; ts = first; bkt = IW'(b); ph = PW'(p);
    cn = !en ? 0 : (first ? (cnt < 8 ? cnt + 1 : 8) : cnt);
    armed = en && cn >= 8;
    f = model_filt(b, p);
    k = 0;
    if (armed) begin
      if (f > int'(thresh)) k = int'(mag);
      else if (f < -int'(thresh)) k = -int'(mag);
    end
    for (int i = 6; i > 0; i--) hm[b][i] = hm[b][i-1];
    hm[b][0] = p;
    cnt = cn;
    @(negedge clk);
    vld = 1'b0; ts = 1'b0;
    chk("R1 valid", int'(kv), 1);
    chk("R1 bucket", int'(bo), b);
    if (!en) chk("R6 gated", int'(ko), k);
    else if (!armed) chk("R5 warmup", int'(ko), k);
    else chk(tag, int'(ko), k);
  endtask

  task automatic idle();
    if (!en) cnt = 0;
    @(negedge clk);
    chk("R1 idle valid", int'(kv), 0);
    chk("R1 idle kick", int'(ko), 0);
  endtask

  function automatic int rnd_phase();
    return int'($urandom_range(0, 16383)) - 8192;
  endfunction

  function automatic int clampp(int v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  // mode 0: random, 1: ramp, 2: constant per bucket
  task automatic run_turn(int mode, int turn, string tag, bit gaps);
    for (int b = 0; b < NB; b++) begin
      int p;
      if (mode == 0) p = rnd_phase();
      else if (mode == 1) p = clampp(base[b] + slope[b] * turn + int'($urandom_range(0, 6)) - 3);
      else p = base[b];
      if (gaps && $urandom_range(0, 7) == 0) idle();
      step(b, p, b == 0, tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < 7; i++) hm[b][i] = 0;
      base[b] = int'($urandom_range(0, 4000)) - 2000;
      slope[b] = int'($urandom_range(0, 80)) - 40;
      if (slope[b] == 0) slope[b] = 7;
    end
    @(negedge clk);
    chk("R1 reset valid", int'(kv), 0);
    chk("R1 reset kick", int'(ko), 0);
    rst_n = 1'b1;
    idle();

    // random phases through warm-up and beyond
    en = 1'b1; thresh = 16'd3000; mag = 11'd700;
    for (int t = 0; t < 10; t++) run_turn(0, t, "R3 random", 1'b1);

    // per-bucket ramps: derivative sign follows slope (R2)
    thresh = 16'd200; mag = 11'd321;
    for (int t = 0; t < 10; t++) run_turn(1, t, "R2 ramp", 1'b0);

    // threshold edge on chosen buckets (R3)
    for (int b = 0; b < NB; b++) begin
      int p = clampp(base[b] + slope[b] * 10);
      int f = model_filt(b, p);
      if (b == 5) thresh = (FW-1)'(iabs(f));
      else if (b == 6 && f != 0) thresh = (FW-1)'(iabs(f) - 1);
      else thresh = 16'd200;
      step(b, p, b == 0, b == 5 ? "R3 edge equal" : (b == 6 ? "R3 edge below" : "R2 ramp"));
    end

    // constant phase, zero threshold (R4)
    thresh = '0;
    for (int t = 0; t < 9; t++) run_turn(2, t, t == 8 ? "R4 dc" : "R3 dc fill", 1'b0);

    // thresholds and magnitude changing per sample (R7)
    for (int t = 0; t < 3; t++) begin
      for (int b = 0; b < NB; b++) begin
        thresh = (FW-1)'($urandom_range(0, 20000));
        mag = (KW-1)'($urandom_range(0, 2047));
        step(b, rnd_phase(), b == 0, "R7 per-sample");
      end
    end

    // disable across turns, history keeps updating (R6), then re-warm (R5)
    en = 1'b0; thresh = 16'd100; mag = 11'd999;
    for (int t = 0; t < 3; t++) run_turn(0, t, "R6", 1'b1);
    en = 1'b1;
    for (int t = 0; t < 10; t++) run_turn(1, t + 20, "R2 after enable", 1'b1);
    mag = 11'd2047; thresh = '0;
    for (int t = 0; t < 2; t++) run_turn(0, t, "R3 full scale", 1'b0);

    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule